// File: doc/BRIEF.md
# PHY-side MII / serial port clock and handshake generator

This block sits on the PHY side of a single Ethernet port that faces an external MAC or routing engine. From one system clock, nominally 50 MHz, it generates the transmit and receive reference clocks the MAC runs on. It chooses the rate from two straps that are captured while reset is held. One strap picks between a nibble-wide MII link and a one-bit serial half-duplex link. The other strap picks the MII line rate.

The block also produces the two half-duplex handshake signals a MAC expects from a PHY on a shared medium. The first is a receive-valid echo of the MAC's own transmit enable. The second is a collision heartbeat pulse after every finished transmission. The serial mode deliberately generates neither of them. Data path muxing and buffering are handled elsewhere.

The rates come from fixed division of the system clock. MII at 100 Mbps divides by 2 (25 MHz). MII at 10 Mbps divides by 20 (2.5 MHz). The serial mode divides by 5 (10 MHz), with a 2-high, 3-low duty cycle.

Top module: `mii_phy_clkgen`

## Requirements
- R1: While reset is held and on the first cycle it is released, both reference clocks, the receive-valid echo and the collision pulse are low.
- R2: MII mode (serial strap 0) with the speed strap at 1 gives reference clocks with a period of 2 system clocks, high for 1.
- R3: MII mode with the speed strap at 0 gives reference clocks with a period of 20 system clocks, high for 10.
- R4: Serial mode (serial strap 1) gives reference clocks with a period of 5 system clocks, high for 2. This holds for either value of the speed strap.
- R5: The transmit and receive reference clocks are identical on every cycle.
- R6: In MII mode, the receive-valid echo rises on the first system clock after TXEN is seen high. It drops in the same cycle that TXEN drops.
- R7: In MII mode, when TXEN falls, the collision pulse starts two bit times later and lasts exactly 10 bit times. One bit time is D system clocks, where D is the divide ratio of the selected rate. Counted from the clock edge that first sees TXEN low, the first collision-high cycle is the (D+2)th to (2D+1)th clock, and the pulse is high for 10*D clocks.
- R8: If TXEN rises again while a heartbeat is pending or running, the heartbeat is dropped. The collision output stays low while TXEN is high. The next TXEN fall starts a full new heartbeat.
- R9: In serial mode, neither the receive-valid echo nor the collision pulse is ever asserted.
- R10: The straps are captured only while reset is held. Changing them afterwards has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 50 MHz) |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| serial_strap_i | input | 1 | 1 = one-bit serial half-duplex mode, 0 = MII mode |
| speed_strap_i | input | 1 | MII rate: 1 = 100 Mbps, 0 = 10 Mbps; ignored in serial mode |
| txen_i | input | 1 | Transmit enable from the MAC |
| tx_clk_o | output | 1 | Transmit reference clock to the MAC |
| rx_clk_o | output | 1 | Receive reference clock to the MAC |
| rxdv_echo_o | output | 1 | Receive-valid echo of TXEN (MII mode only) |
| col_hb_o | output | 1 | Collision heartbeat pulse (MII mode only) |

## Verification
The bench measures clock period and high time at all three rates. It also runs serial mode with both speed-strap values, which would catch a design that lets the speed strap leak into serial timing or that rounds the divide-by-5 duty the wrong way. The heartbeat is timed at both MII rates, so a gap or pulse length counted in system clocks rather than bit times would show up as a wrong length at one of them. Further tests re-raise TXEN during a pending heartbeat and change the straps outside reset. These would expose a heartbeat that fires anyway or a rate that follows the pins live. A last test drives serial-mode transmissions and watches for any echo or collision activity that should be suppressed.

// File: rtl/mii_phy_pkg.sv
package mii_phy_pkg;

   // Index of each rate branch; the generate loop in the top follows this order
   typedef enum logic [1:0] {
      RATE_FAST = 2'd0,
      RATE_SER  = 2'd1,
      RATE_SLOW = 2'd2
   } rate_e;

   localparam int NUM_RATES = 3;

   typedef enum logic [1:0] {
      HB_IDLE = 2'd0,
      HB_GAP  = 2'd1,
      HB_BEAT = 2'd2
   } hb_state_e;

   typedef struct packed {
      logic serial;
      logic speed;
   } straps_t;

   function automatic rate_e pick_rate(straps_t s);
      if (s.serial)     return RATE_SER;
      else if (s.speed) return RATE_FAST;
      else              return RATE_SLOW;
   endfunction

endpackage

// File: rtl/mii_strap_latch.sv
module mii_strap_latch
   import mii_phy_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  straps_t pins_i,
   output straps_t straps_o
);

   straps_t held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) held_q <= pins_i;
   end

   assign straps_o = held_q;

   // R10
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(held_q));

endmodule

// File: rtl/mii_rate_div.sv
module mii_rate_div #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic clk_o,
   output logic tick_o
);

   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int HI = DIV / 2;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);
   localparam logic [CW-1:0] HI_W = CW'(HI);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("mii_rate_div: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          clk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         clk_q <= 1'b0;
      end else begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         clk_q <= (cnt_q < HI_W);
      end
   end

   assign clk_o  = clk_q;
   assign tick_o = rst_n && (cnt_q == '0);

   // R2 R3 R4
   div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/mii_hdx_handshake.sv
module mii_hdx_handshake
   import mii_phy_pkg::*;
#(
   parameter int GAP_BITS  = 2,
   parameter int BEAT_BITS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic serial_i,
   input  logic tick_i,
   input  logic txen_i,
   output logic rxdv_o,
   output logic col_o
);

   localparam int MAXB = (GAP_BITS > BEAT_BITS) ? GAP_BITS : BEAT_BITS;
   localparam int BW   = $clog2(MAXB + 1);
   localparam logic [BW-1:0] GAP_LAST  = BW'(GAP_BITS - 1);
   localparam logic [BW-1:0] BEAT_LAST = BW'(BEAT_BITS - 1);

   generate
      if (GAP_BITS < 1 || BEAT_BITS < 1) begin : g_bad_len
         $error("mii_hdx_handshake: GAP_BITS and BEAT_BITS must be positive");
      end
   endgenerate

   hb_state_e      st_q;
   logic [BW-1:0]  bit_q;
   logic           txen_q;
   logic           echo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= HB_IDLE;
         bit_q  <= '0;
         txen_q <= 1'b0;
         echo_q <= 1'b0;
      end else begin
         txen_q <= txen_i;
         echo_q <= txen_i && !serial_i;
         unique case (st_q)
            HB_IDLE: begin
               if (!serial_i && txen_q && !txen_i) begin
                  st_q  <= HB_GAP;
                  bit_q <= '0;
               end
            end
            HB_GAP: begin
               if (txen_i) begin
                  st_q <= HB_IDLE;
               end else if (tick_i) begin
                  if (bit_q == GAP_LAST) begin
                     st_q  <= HB_BEAT;
                     bit_q <= '0;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
            end
            HB_BEAT: begin
               if (txen_i) begin
                  st_q <= HB_IDLE;
               end else if (tick_i) begin
                  if (bit_q == BEAT_LAST) st_q  <= HB_IDLE;
                  else                    bit_q <= bit_q + 1'b1;
               end
            end
            default: st_q <= HB_IDLE;
         endcase
      end
   end

   assign rxdv_o = echo_q && txen_i;
   assign col_o  = (st_q == HB_BEAT) && !txen_i;

   // R6
   echo_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxdv_o) |-> $past(txen_i));

   // R8
   col_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(col_o) |-> !$past(txen_i));

   // R9
   serial_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serial_i |-> (!rxdv_o && !col_o));

endmodule

// File: rtl/mii_phy_clkgen.sv
module mii_phy_clkgen
   import mii_phy_pkg::*;
#(
   parameter int DIV_FAST  = 2,
   parameter int DIV_SER   = 5,
   parameter int DIV_SLOW  = 20,
   parameter int GAP_BITS  = 2,
   parameter int BEAT_BITS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic serial_strap_i,
   input  logic speed_strap_i,
   input  logic txen_i,
   output logic tx_clk_o,
   output logic rx_clk_o,
   output logic rxdv_echo_o,
   output logic col_hb_o
);

   straps_t pins;
   straps_t straps;
   rate_e   sel;
   logic [NUM_RATES-1:0] div_clk;
   logic [NUM_RATES-1:0] div_tick;
   logic    ref_clk;
   logic    bit_tick;

   assign pins.serial = serial_strap_i;
   assign pins.speed  = speed_strap_i;

   mii_strap_latch u_straps (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_i   (pins),
      .straps_o (straps)
   );

   assign sel = pick_rate(straps);

   for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
      localparam int D = (g == int'(RATE_FAST)) ? DIV_FAST :
                         (g == int'(RATE_SER))  ? DIV_SER  : DIV_SLOW;
      mii_rate_div #(.DIV(D)) u_div (
         .clk    (clk),
         .rst_n  (rst_n),
         .clk_o  (div_clk[g]),
         .tick_o (div_tick[g])
      );
   end

   assign ref_clk  = div_clk[sel];
   assign bit_tick = div_tick[sel];

   assign tx_clk_o = ref_clk;
   assign rx_clk_o = ref_clk;

   mii_hdx_handshake #(
      .GAP_BITS  (GAP_BITS),
      .BEAT_BITS (BEAT_BITS)
   ) u_hdx (
      .clk      (clk),
      .rst_n    (rst_n),
      .serial_i (straps.serial),
      .tick_i   (bit_tick),
      .txen_i   (txen_i),
      .rxdv_o   (rxdv_echo_o),
      .col_o    (col_hb_o)
   );

   // R5
   clk_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clk_o == rx_clk_o);

   // R1
   reset_low_chk: assert property (@(posedge clk)
      !rst_n |=> (!tx_clk_o && !rxdv_echo_o && !col_hb_o));

endmodule

// File: tb/tb_mii_phy_clkgen.sv
module tb_mii_phy_clkgen;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser = 1'b0;
   logic spd = 1'b1;
   logic txen = 1'b0;
   logic tx_clk, rx_clk, rxdv, col;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   mii_phy_clkgen dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .serial_strap_i (ser),
      .speed_strap_i  (spd),
      .txen_i         (txen),
      .tx_clk_o       (tx_clk),
      .rx_clk_o       (rx_clk),
      .rxdv_echo_o    (rxdv),
      .col_hb_o       (col)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic s, input logic p);
      @(negedge clk);
      rst_n = 1'b0; ser = s; spd = p; txen = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: outputs still low right after release (before the first post-reset edge)
      check(!tx_clk && !rx_clk && !rxdv && !col, "R1 reset outputs",
            {tx_clk, rx_clk, rxdv, col}, 0);
   endtask

   task automatic measure(output int per, output int hi, output bit pair_ok);
      logic prev;
      pair_ok = 1'b1;
      prev = tx_clk;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (tx_clk != rx_clk) pair_ok = 1'b0;
         if (!prev && tx_clk) break;
         prev = tx_clk;
      end
      per = 0; hi = 0;
      for (int i = 0; i < 100; i++) begin
         if (tx_clk) hi++;
         if (tx_clk != rx_clk) pair_ok = 1'b0;
         per++;
         @(negedge clk);
         if (!prev && tx_clk && per > 1) break;
         prev = tx_clk;
         if (tx_clk && !prev) break;
      end
   endtask

   task automatic rate_case(input string req, input int exp_per);
      int per, hi;
      bit pr;
      measure(per, hi, pr);
      check(per == exp_per, {req, " period"}, per, exp_per);
      check(hi == exp_per / 2, {req, " high time"}, hi, exp_per / 2);
      check(pr, "R5 tx/rx identical", pr, 1);
   endtask

   task automatic heartbeat(input string req, input int d, output int gap, output int len);
      @(negedge clk);
      txen = 1'b1;
      repeat (8) @(negedge clk);
      txen = 1'b0;
      gap = 0; len = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         gap++;
         if (col) break;
      end
      while (col && len < 400) begin
         len++;
         @(negedge clk);
      end
      check(gap >= d + 2 && gap <= 2 * d + 1, {req, " heartbeat gap"}, gap, d + 2);
      check(len == 10 * d, {req, " heartbeat length"}, len, 10 * d);
   endtask

   task automatic test_echo();
      @(negedge clk);
      txen = 1'b1;
      #1;
      check(rxdv == 1'b0, "R6 echo not same cycle", rxdv, 0);
      @(negedge clk);
      check(rxdv == 1'b1, "R6 echo one clock later", rxdv, 1);
      repeat (3) @(negedge clk);
      txen = 1'b0;
      #1;
      check(rxdv == 1'b0, "R6 echo drops with TXEN", rxdv, 0);
      repeat (60) @(negedge clk);
   endtask

   task automatic test_cancel(input int d);
      int seen, gap, len;
      @(negedge clk);
      txen = 1'b1;
      repeat (4) @(negedge clk);
      txen = 1'b0;
      repeat (d + 3) @(negedge clk);
      txen = 1'b1;
      seen = 0;
      for (int i = 0; i < 40; i++) begin
         #1;
         if (col) seen++;
         @(negedge clk);
      end
      check(seen == 0, "R8 no collision while TXEN high", seen, 0);
      txen = 1'b0;
      gap = 0; len = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         gap++;
         if (col) break;
      end
      while (col && len < 400) begin
         len++;
         @(negedge clk);
      end
      check(len == 10 * d, "R8 restarted heartbeat full length", len, 10 * d);
   endtask

   task automatic test_serial_quiet();
      int hits;
      hits = 0;
      @(negedge clk);
      txen = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (rxdv || col) hits++;
      end
      txen = 1'b0;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (rxdv || col) hits++;
      end
      check(hits == 0, "R9 serial mode no echo/heartbeat", hits, 0);
   endtask

   initial begin
      int gap, len;
      // MII 100 Mbps
      do_reset(1'b0, 1'b1);
      rate_case("R2 MII fast", 2);
      test_echo();
      heartbeat("R7 fast", 2, gap, len);
      test_cancel(2);
      // R10: pins change after reset, rate must stay
      @(negedge clk);
      ser = 1'b1; spd = 1'b0;
      repeat (10) @(negedge clk);
      rate_case("R10 straps ignored after reset", 2);
      // MII 10 Mbps
      do_reset(1'b0, 1'b0);
      rate_case("R3 MII slow", 20);
      heartbeat("R7 slow", 20, gap, len);
      // Serial, both speed strap values
      do_reset(1'b1, 1'b0);
      rate_case("R4 serial spd0", 5);
      test_serial_quiet();
      do_reset(1'b1, 1'b1);
      rate_case("R4 serial spd1", 5);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #400000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule